// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the bus-master DMA channel and interrupt logic of a SCSI host adapter. Host software reaches it through a 128-byte I/O window. The low part of the window passes through to the SCSI core's registers. The middle part holds eight 32-bit DMA channel registers. The top part holds one sideband control word. Any host write may be narrower than a word. Its enabled bytes are merged into the current word value, and the merged word is written as one aligned word.

Once software loads a start count and a start address and issues a start command, the SCSI core may ask for transfer chunks with a length and a direction. The block clips each chunk to the remaining working byte count and presents it on a memory-master command port with a valid/ready handshake. When the port accepts the chunk, the working count falls and the working address rises by the chunk length. The block merges the core's interrupt line with DMA completion into a single interrupt output. A sideband bit picks whether the completion and error status bits clear when written or when read.

Top module: `scsi_dma_chan`

## Requirements
- R1: Decoding uses the byte address `hb_addr`. Addresses 0x00–0x3F reach the core register at index addr[5:2]. Addresses 0x40–0x5F select DMA register addr[4:2]: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, and 6–7 plain storage. Addresses 0x60–0x73 all reach the single sideband word. Addresses 0x74–0x7F read as 0 and ignore writes.
- R2: A write updates only the bytes whose `hb_be` lane bit is set. Every other byte of the target word keeps its current value.
- R3: Writing command field bits[1:0]=3 (start) has four effects. It copies the start count into the working count and the start address into the working address. It clears status bits 3:0 (done, abort, error, power-down). It raises `dma_en`.
- R4: An accepted request issues a chunk at the working address. The chunk length is the smaller of the requested length and the working count. When `mem_valid && mem_ready`, the working count decreases by the chunk length and the working address increases by the same amount.
- R5: `xreq_ready` is high only when the command field equals 3, `dma_en` is high, and no chunk is pending.
- R6: On a rising edge of `core_irq`, status bit 4 is set. In the same update, status bit 3 (done) is set if the command field is 3 and the working count is 0. On a falling edge of `core_irq`, status bit 4 is cleared.
- R7: `irq` equals status bit 4 OR the combination of status bit 3 and command bit 4 (done interrupt enable).
- R8: When sideband bit 24 is 1, a status write clears those of status bits 3:1 that are written as 1, and a status read leaves them unchanged.
- R9: When sideband bit 24 is 0, a status read returns the current value and then clears status bits 3:1, and a status write has no effect.
- R10: Command field 1 (blast) sets status bit 5 and moves no data. Command field 0 (idle) drops `dma_en`. Command field 2 (abort) pulses `dma_abort` for one cycle and drops any pending chunk.
- R11: After reset, every DMA register and the sideband word are 0, and `irq`, `dma_en`, `mem_valid` and `xreq_ready` are low.
- R12: While `mem_valid` is high and `mem_ready` is low, the chunk address, length and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_addr | input | 7 | Host byte address in the window |
| hb_be | input | 4 | Host byte-lane enables for writes |
| hb_wdata | input | 32 | Host write data, lane aligned |
| hb_rdata | output | 32 | Read data for the addressed word (combinational) |
| core_wr | output | 1 | Write strobe to the SCSI core registers |
| core_rd | output | 1 | Read strobe to the SCSI core registers |
| core_idx | output | 4 | Core register index |
| core_wdata | output | 32 | Merged write word for the core |
| core_rdata | input | 32 | Current value of the core register at `core_idx` |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| xreq_valid | input | 1 | Transfer chunk request from the core |
| xreq_len | input | LEN_W | Requested chunk length in bytes |
| xreq_dir | input | 1 | Requested direction (1 = to memory) |
| xreq_ready | output | 1 | Chunk request accepted |
| mem_valid | output | 1 | Memory chunk command valid |
| mem_addr | output | 32 | Chunk start address |
| mem_len | output | LEN_W | Chunk length after clipping |
| mem_dir | output | 1 | Chunk direction |
| mem_ready | input | 1 | Memory side takes the chunk |
| dma_en | output | 1 | DMA transfers enabled |
| dma_abort | output | 1 | One-cycle request to cancel the core's current request |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `core_rdata` already reflects the register that `core_idx` names in the same cycle, and that `core_irq` is a level that changes only between clock edges. They also assume the host never raises `hb_wr` and `hb_rd` together. The stimulus changes all inputs on the falling clock edge and keeps the two host strobes exclusive. The bench's core register model answers combinationally from its own storage. The bench holds `core_irq` for at least two cycles per level, so both of its edges are seen.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned NREG = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  // register indices inside the DMA part of the window
  localparam int unsigned RI_CMD  = 0;
  localparam int unsigned RI_STC  = 1;
  localparam int unsigned RI_SPA  = 2;
  localparam int unsigned RI_WBC  = 3;
  localparam int unsigned RI_WAC  = 4;
  localparam int unsigned RI_STAT = 5;

  // status bits
  localparam int unsigned SB_PDN   = 0;
  localparam int unsigned SB_ERR   = 1;
  localparam int unsigned SB_ABT   = 2;
  localparam int unsigned SB_DONE  = 3;
  localparam int unsigned SB_CORE  = 4;
  localparam int unsigned SB_BLAST = 5;

  // command and sideband bits
  localparam int unsigned CB_DONE_IE = 4;
  localparam int unsigned SW_WCLR    = 24;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] cur,
                                               input logic [DW-1:0] nw,
                                               input logic [DW/8-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < DW/8; b++) begin
      r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : cur[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/scsi_dma_decode.sv
module scsi_dma_decode
  import scsi_dma_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic [AW-1:0]   addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  logic            wr,
  input  logic            rd,
  input  logic [DW-1:0]   core_cur,
  input  logic [DW-1:0]   dma_cur,
  input  logic [DW-1:0]   side_cur,
  output logic            core_wr,
  output logic            core_rd,
  output logic [3:0]      core_idx,
  output logic            dma_wr,
  output logic            dma_rd,
  output logic [2:0]      dma_idx,
  output logic            side_wr,
  output logic [DW-1:0]   wword,
  output logic [DW-1:0]   rdata
);
  localparam logic [AW-1:0] CORE_END = AW'(8'h40);
  localparam logic [AW-1:0] DMA_END  = AW'(8'h60);
  localparam logic [AW-1:0] SIDE_END = AW'(8'h74);

  logic in_core, in_dma, in_side;
  logic [DW-1:0] cur;

  always_comb begin
    in_core = addr < CORE_END;
    in_dma  = !in_core && (addr < DMA_END);
    in_side = (addr >= DMA_END) && (addr < SIDE_END);
    core_idx = addr[5:2];
    dma_idx  = addr[4:2];
    if (in_core)      cur = core_cur;
    else if (in_dma)  cur = dma_cur;
    else if (in_side) cur = side_cur;
    else              cur = '0;
    wword   = lane_merge(cur, wdata, be);
    rdata   = cur;
    core_wr = wr && in_core;
    core_rd = rd && in_core;
    dma_wr  = wr && in_dma;
    dma_rd  = rd && in_dma;
    side_wr = wr && in_side;
  end
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
  import scsi_dma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_wr,
  input  logic             dma_rd,
  input  logic [2:0]       dma_idx,
  input  logic             side_wr,
  input  logic [DW-1:0]    wword,
  input  logic             core_irq,
  input  logic             chunk_done,
  input  logic [LEN_W-1:0] chunk_len,
  output logic [DW-1:0]    dma_cur,
  output logic [DW-1:0]    side_cur,
  output logic [DW-1:0]    wbc,
  output logic [DW-1:0]    wac,
  output logic             op_start,
  output logic             dma_en,
  output logic             dma_abort,
  output logic             irq
);
  logic [DW-1:0] rq [NREG];
  logic [DW-1:0] rn [NREG];
  logic [DW-1:0] side_q, side_n;
  logic          en_q, en_n;
  logic          abt_q, abt_n;
  logic          ip_q;
  logic          rise, fall, cmd_wr;
  dma_op_e       op_w;

  always_comb begin
    rn     = rq;
    side_n = side_q;
    en_n   = en_q;
    abt_n  = 1'b0;
    rise   = core_irq && !ip_q;
    fall   = !core_irq && ip_q;
    cmd_wr = dma_wr && (dma_idx == 3'(RI_CMD));
    op_w   = dma_op_e'(wword[1:0]);

    if (chunk_done) begin
      rn[RI_WBC] = rq[RI_WBC] - DW'(chunk_len);
      rn[RI_WAC] = rq[RI_WAC] + DW'(chunk_len);
    end

    if (dma_rd && (dma_idx == 3'(RI_STAT)) && !side_q[SW_WCLR])
      rn[RI_STAT][SB_DONE:SB_ERR] = 3'b000;

    if (rise) begin
      rn[RI_STAT][SB_CORE] = 1'b1;
      if ((rq[RI_CMD][1:0] == OP_START) && (rq[RI_WBC] == '0))
        rn[RI_STAT][SB_DONE] = 1'b1;
    end else if (fall) begin
      rn[RI_STAT][SB_CORE] = 1'b0;
    end

    if (side_wr) side_n = wword;

    if (dma_wr) begin
      if (dma_idx == 3'(RI_STAT)) begin
        if (side_q[SW_WCLR])
          rn[RI_STAT][SB_DONE:SB_ERR] = rn[RI_STAT][SB_DONE:SB_ERR] & ~wword[SB_DONE:SB_ERR];
      end else begin
        rn[dma_idx] = wword;
      end
      if (cmd_wr) begin
        unique case (op_w)
          OP_IDLE:  en_n = 1'b0;
          OP_BLAST: rn[RI_STAT][SB_BLAST] = 1'b1;
          OP_ABORT: abt_n = 1'b1;
          OP_START: begin
            rn[RI_WBC] = rq[RI_STC];
            rn[RI_WAC] = rq[RI_SPA];
            rn[RI_STAT][SB_DONE:SB_PDN] = 4'b0000;
            en_n = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rq[i] <= '0;
      side_q <= '0;
      en_q   <= 1'b0;
      abt_q  <= 1'b0;
      ip_q   <= 1'b0;
    end else begin
      rq     <= rn;
      side_q <= side_n;
      en_q   <= en_n;
      abt_q  <= abt_n;
      ip_q   <= core_irq;
    end
  end

  assign dma_cur   = rq[dma_idx];
  assign side_cur  = side_q;
  assign wbc       = rq[RI_WBC];
  assign wac       = rq[RI_WAC];
  assign op_start  = rq[RI_CMD][1:0] == OP_START;
  assign dma_en    = en_q;
  assign dma_abort = abt_q;
  assign irq       = rq[RI_STAT][SB_CORE] | (rq[RI_CMD][CB_DONE_IE] & rq[RI_STAT][SB_DONE]);

  // R6: a core interrupt edge is recorded in status on the following cycle
  a_r6_core_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_irq) |=> rq[RI_STAT][SB_CORE]);

  // R3: start loads the working count, clears low status, enables DMA
  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && dma_idx == 3'(RI_CMD) && wword[1:0] == OP_START)
      |=> (rq[RI_WBC] == $past(rq[RI_STC])) && (rq[RI_STAT][3:0] == 4'b0000) && en_q);

  // R4: a finished chunk moves the working count down by its length
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done && !dma_wr) |=> rq[RI_WBC] == $past(rq[RI_WBC]) - DW'($past(chunk_len)));

  // R10: blast leaves its mark in status
  a_r10_blast_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && dma_idx == 3'(RI_CMD) && wword[1:0] == OP_BLAST) |=> rq[RI_STAT][SB_BLAST]);
endmodule

// File: rtl/scsi_dma_xfer.sv
module scsi_dma_xfer
  import scsi_dma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_dir,
  output logic             req_ready,
  input  logic             op_start,
  input  logic             dma_en,
  input  logic             abort,
  input  logic [DW-1:0]    wbc,
  input  logic [DW-1:0]    wac,
  output logic             mem_valid,
  output logic [DW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic             mem_dir,
  input  logic             mem_ready,
  output logic             chunk_done,
  output logic [LEN_W-1:0] chunk_len
);
  logic             busy_q, busy_n;
  logic [LEN_W-1:0] len_q, len_n, clip;
  logic [DW-1:0]    addr_q, addr_n;
  logic             dir_q, dir_n;
  logic             accept, fin;

  always_comb begin
    req_ready = dma_en && op_start && !busy_q;
    accept    = req_valid && req_ready;
    fin       = busy_q && mem_ready;
    clip      = (wbc < DW'(req_len)) ? wbc[LEN_W-1:0] : req_len;
    busy_n = busy_q;
    len_n  = len_q;
    addr_n = addr_q;
    dir_n  = dir_q;
    if (abort || fin) begin
      busy_n = 1'b0;
    end else if (accept) begin
      busy_n = 1'b1;
      len_n  = clip;
      addr_n = wac;
      dir_n  = req_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      len_q  <= '0;
      addr_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      len_q  <= len_n;
      addr_q <= addr_n;
      dir_q  <= dir_n;
    end
  end

  assign mem_valid  = busy_q;
  assign mem_addr   = addr_q;
  assign mem_len    = len_q;
  assign mem_dir    = dir_q;
  assign chunk_done = fin && !abort;
  assign chunk_len  = len_q;

  // R12: a waiting chunk holds still
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !abort)
      |=> mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_dir));

  // R5: an accepted request shows up on the memory port next cycle
  a_r5_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !abort) |=> mem_valid);

  // R4: the issued chunk never exceeds the count it was clipped against
  a_r4_clip: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !abort) |=> DW'(mem_len) <= $past(wbc));
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned AW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_wr,
  input  logic             hb_rd,
  input  logic [AW-1:0]    hb_addr,
  input  logic [3:0]       hb_be,
  input  logic [31:0]      hb_wdata,
  output logic [31:0]      hb_rdata,
  output logic             core_wr,
  output logic             core_rd,
  output logic [3:0]       core_idx,
  output logic [31:0]      core_wdata,
  input  logic [31:0]      core_rdata,
  input  logic             core_irq,
  input  logic             xreq_valid,
  input  logic [LEN_W-1:0] xreq_len,
  input  logic             xreq_dir,
  output logic             xreq_ready,
  output logic             mem_valid,
  output logic [31:0]      mem_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic             mem_dir,
  input  logic             mem_ready,
  output logic             dma_en,
  output logic             dma_abort,
  output logic             irq
);
  logic             dma_wr, dma_rd, side_wr, op_start, chunk_done;
  logic [2:0]       dma_idx;
  logic [DW-1:0]    wword, dma_cur, side_cur, wbc, wac;
  logic [LEN_W-1:0] chunk_len;

  scsi_dma_decode #(.AW(AW)) u_dec (
    .addr(hb_addr), .be(hb_be), .wdata(hb_wdata), .wr(hb_wr), .rd(hb_rd),
    .core_cur(core_rdata), .dma_cur(dma_cur), .side_cur(side_cur),
    .core_wr(core_wr), .core_rd(core_rd), .core_idx(core_idx),
    .dma_wr(dma_wr), .dma_rd(dma_rd), .dma_idx(dma_idx),
    .side_wr(side_wr), .wword(wword), .rdata(hb_rdata)
  );

  assign core_wdata = wword;

  scsi_dma_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .dma_wr(dma_wr), .dma_rd(dma_rd),
    .dma_idx(dma_idx), .side_wr(side_wr), .wword(wword),
    .core_irq(core_irq), .chunk_done(chunk_done), .chunk_len(chunk_len),
    .dma_cur(dma_cur), .side_cur(side_cur), .wbc(wbc), .wac(wac),
    .op_start(op_start), .dma_en(dma_en), .dma_abort(dma_abort), .irq(irq)
  );

  scsi_dma_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .req_valid(xreq_valid), .req_len(xreq_len),
    .req_dir(xreq_dir), .req_ready(xreq_ready), .op_start(op_start),
    .dma_en(dma_en), .abort(dma_abort), .wbc(wbc), .wac(wac),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_dir(mem_dir), .mem_ready(mem_ready), .chunk_done(chunk_done),
    .chunk_len(chunk_len)
  );

  // R7: the interrupt never rises without a core edge or a status/enable change
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(core_irq) || core_irq || $past(hb_wr)));
endmodule

// File: tb/sim_scsi_dma_chan.sv
module sim_scsi_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hb_wr, hb_rd;
  logic [6:0]  hb_addr;
  logic [3:0]  hb_be;
  logic [31:0] hb_wdata, hb_rdata;
  logic        core_wr, core_rd;
  logic [3:0]  core_idx;
  logic [31:0] core_wdata, core_rdata;
  logic        core_irq;
  logic        xreq_valid, xreq_dir, xreq_ready;
  logic [15:0] xreq_len, mem_len;
  logic        mem_valid, mem_dir, mem_ready;
  logic [31:0] mem_addr;
  logic        dma_en, dma_abort, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  scsi_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
    .hb_be(hb_be), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .core_wr(core_wr), .core_rd(core_rd), .core_idx(core_idx),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_irq(core_irq),
    .xreq_valid(xreq_valid), .xreq_len(xreq_len), .xreq_dir(xreq_dir),
    .xreq_ready(xreq_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_dir(mem_dir), .mem_ready(mem_ready),
    .dma_en(dma_en), .dma_abort(dma_abort), .irq(irq)
  );

  // simple model of the SCSI core register bank
  logic [31:0] core_mem [16];
  always @(posedge clk) if (core_wr) core_mem[core_idx] <= core_wdata;
  assign core_rdata = core_mem[core_idx];

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'h44, 4'hF, 32'h0000_1234, 32'h0},           // R1 start count
    '{1'b0, 7'h44, 4'h0, 32'h0,         32'h0000_1234},
    '{1'b1, 7'h46, 4'hC, 32'hABCD_0000, 32'h0},           // R2 upper half
    '{1'b0, 7'h44, 4'h0, 32'h0,         32'hABCD_1234},
    '{1'b1, 7'h48, 4'h1, 32'h0000_00EE, 32'h0},           // R2 single byte
    '{1'b0, 7'h48, 4'h0, 32'h0,         32'h0000_00EE},
    '{1'b1, 7'h08, 4'hF, 32'h1122_3344, 32'h0},           // R1 core index 2
    '{1'b1, 7'h09, 4'h2, 32'h0000_AA00, 32'h0},           // R2 core merge
    '{1'b0, 7'h08, 4'h0, 32'h0,         32'h1122_AA44},
    '{1'b1, 7'h60, 4'hF, 32'h0100_0000, 32'h0},           // R1 sideband
    '{1'b0, 7'h70, 4'h0, 32'h0,         32'h0100_0000},   // R1 alias
    '{1'b1, 7'h64, 4'hF, 32'h0000_0000, 32'h0},
    '{1'b1, 7'h78, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R1 unmapped
    '{1'b0, 7'h78, 4'h0, 32'h0,         32'h0},
    '{1'b1, 7'h5C, 4'hF, 32'h0000_5A5A, 32'h0},           // R1 spare reg 7
    '{1'b0, 7'h5C, 4'h0, 32'h0,         32'h0000_5A5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [6:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = a; hb_be = be; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0; hb_be = 4'h0;
  endtask

  task automatic hread(input string req, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    hb_rd = 1'b1; hb_addr = a;
    #1 chk(req, hb_rdata, exp);
    @(negedge clk);
    hb_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic irq_pulse();
    @(negedge clk); core_irq = 1'b1;
    wait_cyc(2);
    core_irq = 1'b0;
    wait_cyc(2);
  endtask

  task automatic chunk(input logic [15:0] len, input logic dir,
                       input logic [31:0] ea, input logic [15:0] el);
    @(negedge clk);
    xreq_valid = 1'b1; xreq_len = len; xreq_dir = dir;
    #1 chk("R5 ready in start", {31'b0, xreq_ready}, 32'd1);
    @(negedge clk);
    xreq_valid = 1'b0;
    chk("R4 mem_valid", {31'b0, mem_valid}, 32'd1);
    chk("R4 mem_addr", mem_addr, ea);
    chk("R4 mem_len clipped", {16'b0, mem_len}, {16'b0, el});
    chk("R4 mem_dir", {31'b0, mem_dir}, {31'b0, dir});
    @(negedge clk);
    chk("R12 addr held", mem_addr, ea);
    chk("R12 len held", {16'b0, mem_len}, {16'b0, el});
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R4 port freed", {31'b0, mem_valid}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hb_wr = 1'b0; hb_rd = 1'b0; hb_addr = '0; hb_be = '0;
    hb_wdata = '0; core_irq = 1'b0; xreq_valid = 1'b0; xreq_len = '0;
    xreq_dir = 1'b0; mem_ready = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 32'd0);
    chk("R11 dma_en", {31'b0, dma_en}, 32'd0);
    chk("R11 mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R11 xreq_ready", {31'b0, xreq_ready}, 32'd0);
    hread("R11 cmd", 7'h40, 32'h0);
    hread("R11 status", 7'h54, 32'h0);
    hread("R11 sideband", 7'h60, 32'h0);

    // table walk: R1 decode and R2 lane merge
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) hwrite(VECS[i].addr, VECS[i].be, VECS[i].data);
      else hread("R1/R2 table", VECS[i].addr, VECS[i].exp);
    end

    // R5 refused while idle
    @(negedge clk); xreq_valid = 1'b1; xreq_len = 16'd4;
    #1 chk("R5 refused idle", {31'b0, xreq_ready}, 32'd0);
    @(negedge clk); xreq_valid = 1'b0;

    // R3 start
    hwrite(7'h44, 4'hF, 32'd10);
    hwrite(7'h48, 4'hF, 32'h1000);
    hwrite(7'h40, 4'hF, 32'h13);
    chk("R3 dma_en", {31'b0, dma_en}, 32'd1);
    hread("R3 wbc", 7'h4C, 32'd10);
    hread("R3 wac", 7'h50, 32'h1000);
    hread("R3 status cleared", 7'h54, 32'h0);

    // R4/R12 chunks, second one clipped
    chunk(16'd4, 1'b1, 32'h1000, 16'd4);
    hread("R4 wbc after 1", 7'h4C, 32'd6);
    hread("R4 wac after 1", 7'h50, 32'h1004);
    chunk(16'd9, 1'b0, 32'h1004, 16'd6);
    hread("R4 wbc after 2", 7'h4C, 32'd0);
    hread("R4 wac after 2", 7'h50, 32'h100A);

    // R6 core interrupt with completion, read-clear mode
    @(negedge clk); core_irq = 1'b1;
    wait_cyc(2);
    chk("R7 irq from core", {31'b0, irq}, 32'd1);
    hread("R6 done and core bit", 7'h54, 32'h18);
    hread("R9 read cleared done", 7'h54, 32'h10);
    core_irq = 1'b0;
    wait_cyc(2);
    hread("R6 fall clears core bit", 7'h54, 32'h0);
    chk("R7 irq low", {31'b0, irq}, 32'd0);

    // R6 no completion while count nonzero
    hwrite(7'h44, 4'hF, 32'd10);
    hwrite(7'h40, 4'hF, 32'h03);
    @(negedge clk); core_irq = 1'b1;
    wait_cyc(2);
    hread("R6 no done with count", 7'h54, 32'h10);
    core_irq = 1'b0;
    wait_cyc(2);

    // R7 done gated by enable; R9 write ignored in read-clear mode
    hwrite(7'h44, 4'hF, 32'd0);
    hwrite(7'h40, 4'hF, 32'h03);
    irq_pulse();
    chk("R7 done without enable", {31'b0, irq}, 32'd0);
    hwrite(7'h54, 4'hF, 32'h0E);
    hwrite(7'h40, 4'hF, 32'h10);
    chk("R10 idle drops dma_en", {31'b0, dma_en}, 32'd0);
    chk("R7 done with enable", {31'b0, irq}, 32'd1);
    hread("R9 write had no effect", 7'h54, 32'h08);
    chk("R9 read cleared irq", {31'b0, irq}, 32'd0);

    // R8 write-clear mode
    hwrite(7'h60, 4'hF, 32'h0100_0000);
    hwrite(7'h40, 4'hF, 32'h13);
    irq_pulse();
    hread("R8 done set", 7'h54, 32'h08);
    hread("R8 read keeps done", 7'h54, 32'h08);
    chk("R8 irq held", {31'b0, irq}, 32'd1);
    hwrite(7'h54, 4'hF, 32'h08);
    hread("R8 write cleared", 7'h54, 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 32'd0);

    // R10 blast and abort
    hwrite(7'h40, 4'hF, 32'h01);
    hread("R10 blast bit", 7'h54, 32'h20);
    chk("R5 refused in blast", {31'b0, xreq_ready}, 32'd0);
    hwrite(7'h40, 4'hF, 32'h02);
    chk("R10 abort pulse", {31'b0, dma_abort}, 32'd1);
    @(negedge clk);
    chk("R10 abort one cycle", {31'b0, dma_abort}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule